// File: doc/BRIEF.md
# Fine-Grained Trap Register Access Checker

This block sits beside the system-register decoder of a core. Each access request carries a read/write flag, the five encoding fields and the write data. The block first decides whether the request targets the hypervisor's fine-grained instruction-trap control register. If it does, the block chooses one of five outcomes from the current exception level and the virtualization, monitor and debug state:

- plain register access;
- redirection to a memory-backed copy of the register;
- trap to the hypervisor level;
- trap to the monitor level;
- undefined instruction.

The block also holds the register itself. A direct write updates the stored value on the next clock edge. A direct read returns the stored value in the same cycle. Every other outcome returns zero on the read port. A request with a different encoding is declined on a separate output, so that another decoder can claim it.

A parameter selects between two priority chains for the halted-debug case at the hypervisor level. Both chains produce the same outcome for every input combination.

Top module: `ftrap_access_chk`

## Requirements
- R1: A valid request matches only when op0=3, op1=4, CRn=1, CRm=1 and op2=6, for reads and for writes alike. A valid request that does not match drives `notMine`=1 and outcome 0. With `reqValid`=0, both `notMine` and the outcome are 0. Outcome codes are: 0 none, 1 direct, 2 redirect, 3 hypervisor trap, 4 monitor trap, 5 undefined.
- R2: A matching access at exception level 0 (`curEl`=0) gives outcome 5, whatever the other flags are.
- R3: At level 1, with `hypEn`, `nvBit` and `nv2Bit` all 1, the outcome is 2 and `redirOffset` is 0x1C8.
- R4: At level 1, with `hypEn`=1, `nvBit`=1 and `nv2Bit`=0, the outcome is 3. Any other level-1 flag combination gives outcome 5.
- R5: At level 2, with `monPresent`=1 and `monFtEn`=0, the outcome is 4. The exception is when `dbgHalted`=1 and `secDbgOff`=1: the outcome is then 5.
- R6: At level 2 with no blocking condition, the outcome is 1. Level 3 always gives outcome 1.
- R7: `trapClass` is 0x18 on outcomes 3 and 4 and 0 otherwise. `redirOffset` is 0 on every outcome except 2.
- R8: A direct read returns the stored value on `rdata`. Every other outcome, and every write, returns zero on `rdata`.
- R9: A direct write stores `reqWdata` masked to bits 54:0 on the next clock edge, so bits 63:55 always read zero. A write with any outcome other than 1 leaves the stored value unchanged.
- R10: After reset, the stored value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOp0 | input | 2 | Encoding field op0 |
| reqOp1 | input | 3 | Encoding field op1 |
| reqCrn | input | 4 | Encoding field CRn |
| reqCrm | input | 4 | Encoding field CRm |
| reqOp2 | input | 3 | Encoding field op2 |
| reqWdata | input | 64 | Write data |
| curEl | input | 2 | Current exception level |
| nvBit | input | 1 | Nested virtualization enable |
| nv2Bit | input | 1 | Nested virtualization memory-redirect enable |
| hypEn | input | 1 | Hypervisor level implemented and enabled |
| monPresent | input | 1 | Monitor level implemented |
| monFtEn | input | 1 | Monitor's fine-trap enable |
| dbgHalted | input | 1 | Core in halted debug state |
| secDbgOff | input | 1 | Secure debug disabled |
| outcome | output | 3 | Access outcome code |
| notMine | output | 1 | Valid request with a foreign encoding |
| trapClass | output | 6 | Exception class for traps |
| redirOffset | output | 12 | Offset of the memory-backed copy |
| rdata | output | 64 | Read data |

## Verification
Every exception level is swept across all 128 combinations of the seven state flags, once as a read and once as a write. This separates the redirect case from the hypervisor trap at level 1, and the monitor trap from the halted-debug undefined case at level 2. Encodings that differ from the match in exactly one field show that each field is compared on its own. Trapped and redirected writes are followed by level-3 reads, which show that no outcome other than direct access changes the stored value. Writes with random data expose the masking of the reserved high bits.

// File: rtl/ftrap_pkg.sv
package ftrap_pkg;

  typedef enum logic [2:0] {
    OUT_NONE     = 3'd0,
    OUT_DIRECT   = 3'd1,
    OUT_REDIR    = 3'd2,
    OUT_TRAP_HYP = 3'd3,
    OUT_TRAP_MON = 3'd4,
    OUT_UNDEF    = 3'd5
  } outcome_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } dpStrobes_t;

  localparam logic [1:0]  ENC_OP0 = 2'd3;
  localparam logic [2:0]  ENC_OP1 = 3'd4;
  localparam logic [3:0]  ENC_CRN = 4'd1;
  localparam logic [3:0]  ENC_CRM = 4'd1;
  localparam logic [2:0]  ENC_OP2 = 3'd6;

  localparam logic [5:0]  TRAP_CLASS = 6'h18;
  localparam logic [11:0] SHADOW_OFS = 12'h1C8;

endpackage

// File: rtl/ftrap_ctrl.sv
module ftrap_ctrl
  import ftrap_pkg::*;
#(
  parameter bit EARLY_HALT_CHECK = 1'b0
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqOp0,
  input  logic [2:0]       reqOp1,
  input  logic [3:0]       reqCrn,
  input  logic [3:0]       reqCrm,
  input  logic [2:0]       reqOp2,
  input  logic [1:0]       curEl,
  input  logic             nvBit,
  input  logic             nv2Bit,
  input  logic             hypEn,
  input  logic             monPresent,
  input  logic             monFtEn,
  input  logic             dbgHalted,
  input  logic             secDbgOff,
  output outcome_e         outcome,
  output logic             notMine,
  output logic [5:0]       trapClass,
  output logic [11:0]      redirOffset,
  output dpStrobes_t       strobes
);

  logic encMatch;
  outcome_e el1Res;
  outcome_e el2Res;
  logic monBlock;
  logic haltBlock;

  assign encMatch = (reqOp0 == ENC_OP0) && (reqOp1 == ENC_OP1) &&
                    (reqCrn == ENC_CRN) && (reqCrm == ENC_CRM) &&
                    (reqOp2 == ENC_OP2);

  assign monBlock  = monPresent && !monFtEn;
  assign haltBlock = dbgHalted && secDbgOff;

  // level 1: redirect beats hypervisor trap
  always_comb begin
    if (hypEn && nvBit && nv2Bit)  el1Res = OUT_REDIR;
    else if (hypEn && nvBit)       el1Res = OUT_TRAP_HYP;
    else                           el1Res = OUT_UNDEF;
  end

  // level 2: two equivalent priority chains
  generate
    if (EARLY_HALT_CHECK) begin : g_early
      always_comb begin
        if (haltBlock && monBlock) el2Res = OUT_UNDEF;
        else if (monBlock)         el2Res = OUT_TRAP_MON;
        else                       el2Res = OUT_DIRECT;
      end
    end else begin : g_nested
      always_comb begin
        if (monBlock) el2Res = haltBlock ? OUT_UNDEF : OUT_TRAP_MON;
        else          el2Res = OUT_DIRECT;
      end
    end
  endgenerate

  always_comb begin
    outcome = OUT_NONE;
    notMine = 1'b0;
    if (reqValid) begin
      if (!encMatch) begin
        notMine = 1'b1;
      end else begin
        unique case (curEl)
          2'd0:    outcome = OUT_UNDEF;
          2'd1:    outcome = el1Res;
          2'd2:    outcome = el2Res;
          default: outcome = OUT_DIRECT;
        endcase
      end
    end
  end

  assign trapClass   = (outcome == OUT_TRAP_HYP || outcome == OUT_TRAP_MON) ? TRAP_CLASS : 6'd0;
  assign redirOffset = (outcome == OUT_REDIR) ? SHADOW_OFS : 12'd0;

  assign strobes.wrStb = (outcome == OUT_DIRECT) && reqWrite;
  assign strobes.rdStb = (outcome == OUT_DIRECT) && !reqWrite;

endmodule

// File: rtl/ftrap_dpath.sv
module ftrap_dpath
  import ftrap_pkg::*;
#(
  parameter int              REG_W     = 64,
  parameter logic [REG_W-1:0] KEEP_MASK = 64'h007F_FFFF_FFFF_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [REG_W-1:0] reqWdata,
  output logic [REG_W-1:0] rdata
);

  logic [REG_W-1:0] trapReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              trapReg <= '0;
    else if (strobes.wrStb) trapReg <= reqWdata & KEEP_MASK;
  end

  assign rdata = strobes.rdStb ? trapReg : '0;

endmodule

// File: rtl/ftrap_access_chk.sv
module ftrap_access_chk
  import ftrap_pkg::*;
#(
  parameter int               REG_W            = 64,
  parameter logic [REG_W-1:0] KEEP_MASK        = 64'h007F_FFFF_FFFF_FFFF,
  parameter bit               EARLY_HALT_CHECK = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqOp0,
  input  logic [2:0]       reqOp1,
  input  logic [3:0]       reqCrn,
  input  logic [3:0]       reqCrm,
  input  logic [2:0]       reqOp2,
  input  logic [REG_W-1:0] reqWdata,
  input  logic [1:0]       curEl,
  input  logic             nvBit,
  input  logic             nv2Bit,
  input  logic             hypEn,
  input  logic             monPresent,
  input  logic             monFtEn,
  input  logic             dbgHalted,
  input  logic             secDbgOff,
  output logic [2:0]       outcome,
  output logic             notMine,
  output logic [5:0]       trapClass,
  output logic [11:0]      redirOffset,
  output logic [REG_W-1:0] rdata
);

  outcome_e   outcomeInt;
  dpStrobes_t strobes;

  ftrap_ctrl #(.EARLY_HALT_CHECK(EARLY_HALT_CHECK)) ctrl_i (
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqOp0     (reqOp0),
    .reqOp1     (reqOp1),
    .reqCrn     (reqCrn),
    .reqCrm     (reqCrm),
    .reqOp2     (reqOp2),
    .curEl      (curEl),
    .nvBit      (nvBit),
    .nv2Bit     (nv2Bit),
    .hypEn      (hypEn),
    .monPresent (monPresent),
    .monFtEn    (monFtEn),
    .dbgHalted  (dbgHalted),
    .secDbgOff  (secDbgOff),
    .outcome    (outcomeInt),
    .notMine    (notMine),
    .trapClass  (trapClass),
    .redirOffset(redirOffset),
    .strobes    (strobes)
  );

  ftrap_dpath #(.REG_W(REG_W), .KEEP_MASK(KEEP_MASK)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqWdata(reqWdata),
    .rdata   (rdata)
  );

  assign outcome = outcomeInt;

endmodule

// File: rtl/ftrap_access_chk_sva.sv
module ftrap_access_chk_sva #(
  parameter int               REG_W     = 64,
  parameter logic [REG_W-1:0] KEEP_MASK = 64'h007F_FFFF_FFFF_FFFF
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [1:0]       reqOp0,
  input logic [2:0]       reqOp1,
  input logic [3:0]       reqCrn,
  input logic [3:0]       reqCrm,
  input logic [2:0]       reqOp2,
  input logic [REG_W-1:0] reqWdata,
  input logic [1:0]       curEl,
  input logic             nvBit,
  input logic             nv2Bit,
  input logic             hypEn,
  input logic             monPresent,
  input logic             monFtEn,
  input logic             dbgHalted,
  input logic             secDbgOff,
  input logic [2:0]       outcome,
  input logic             notMine,
  input logic [5:0]       trapClass,
  input logic [11:0]      redirOffset,
  input logic [REG_W-1:0] rdata
);

  logic hit;
  assign hit = reqValid && reqOp0 == 2'd3 && reqOp1 == 3'd4 && reqCrn == 4'd1 &&
               reqCrm == 4'd1 && reqOp2 == 3'd6;

  p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    notMine |-> (outcome == 3'd0 && rdata == '0));

  p_el0_undef_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd0) |-> outcome == 3'd5);

  p_redirect_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd1 && hypEn && nvBit && nv2Bit) |-> (outcome == 3'd2 && redirOffset == 12'h1C8));

  p_hyp_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd1 && hypEn && nvBit && !nv2Bit) |-> outcome == 3'd3);

  p_mon_trap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd2 && monPresent && !monFtEn && !(dbgHalted && secDbgOff)) |-> outcome == 3'd4);

  p_el3_direct_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd3) |-> outcome == 3'd1);

  p_class_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outcome != 3'd3 && outcome != 3'd4) |-> trapClass == 6'd0);

  p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outcome != 3'd1 || reqWrite) |-> rdata == '0);

  p_write_then_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && outcome == 3'd1) ##1 (reqValid && !reqWrite && outcome == 3'd1)
      |-> rdata == ($past(reqWdata) & KEEP_MASK));

  always_comb begin
    if (rstN) begin
      a_reserved_zero_r9: assert ((rdata & ~KEEP_MASK) == '0);
    end
  end

endmodule

bind ftrap_access_chk ftrap_access_chk_sva #(.REG_W(REG_W), .KEEP_MASK(KEEP_MASK)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
  .reqWdata(reqWdata), .curEl(curEl), .nvBit(nvBit), .nv2Bit(nv2Bit), .hypEn(hypEn),
  .monPresent(monPresent), .monFtEn(monFtEn), .dbgHalted(dbgHalted), .secDbgOff(secDbgOff),
  .outcome(outcome), .notMine(notMine), .trapClass(trapClass), .redirOffset(redirOffset),
  .rdata(rdata)
);

// File: tb/ftrap_access_chk_tb_top.sv
module ftrap_access_chk_tb_top;

  localparam logic [63:0] MASK = 64'h007F_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqOp0 = '0;
  logic [2:0] reqOp1 = '0;
  logic [3:0] reqCrn = '0, reqCrm = '0;
  logic [2:0] reqOp2 = '0;
  logic [63:0] reqWdata = '0;
  logic [1:0] curEl = '0;
  logic nvBit = 0, nv2Bit = 0, hypEn = 0, monPresent = 0, monFtEn = 0, dbgHalted = 0, secDbgOff = 0;
  logic [2:0] outcome;
  logic notMine;
  logic [5:0] trapClass;
  logic [11:0] redirOffset;
  logic [63:0] rdata;

  int nChecks = 0;
  int nErrors = 0;
  logic [63:0] modelReg = '0;

  always #4 clk = ~clk;  // 125 MHz

  ftrap_access_chk dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .reqWdata(reqWdata), .curEl(curEl), .nvBit(nvBit), .nv2Bit(nv2Bit), .hypEn(hypEn),
    .monPresent(monPresent), .monFtEn(monFtEn), .dbgHalted(dbgHalted), .secDbgOff(secDbgOff),
    .outcome(outcome), .notMine(notMine), .trapClass(trapClass), .redirOffset(redirOffset),
    .rdata(rdata)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent reference of the outcome rules
  function automatic int refOutcome(bit valid, bit match, int el, bit [6:0] f);
    bit nv = f[0], nv2 = f[1], hyp = f[2], mon = f[3], en = f[4], hlt = f[5], sdd = f[6];
    if (!valid || !match) return 0;
    if (el == 0) return 5;
    if (el == 1) begin
      if (hyp && nv && nv2) return 2;
      if (hyp && nv) return 3;
      return 5;
    end
    if (el == 2) begin
      if (mon && !en && hlt && sdd) return 5;
      if (mon && !en) return 4;
      return 1;
    end
    return 1;
  endfunction

  function automatic string tagFor(int el, int exp);
    if (el == 0) return "R2";
    if (el == 1) return (exp == 2) ? "R3" : "R4";
    if (el == 2) return (exp == 1) ? "R6" : "R5";
    return "R6";
  endfunction

  // drive after negedge, sample 2 ns later, model update at the following edge
  task automatic doOp(bit valid, bit wr, bit [1:0] o0, bit [2:0] o1, bit [3:0] cn, bit [3:0] cm,
                      bit [2:0] o2, logic [63:0] wd, int el, bit [6:0] f);
    int exp;
    bit match;
    @(negedge clk);
    reqValid = valid; reqWrite = wr; reqOp0 = o0; reqOp1 = o1; reqCrn = cn; reqCrm = cm;
    reqOp2 = o2; reqWdata = wd; curEl = 2'(el);
    {secDbgOff, dbgHalted, monFtEn, monPresent, hypEn, nv2Bit, nvBit} = f;
    #2;
    match = (o0 == 2'd3 && o1 == 3'd4 && cn == 4'd1 && cm == 4'd1 && o2 == 3'd6);
    exp = refOutcome(valid, match, el, f);
    check(match ? tagFor(el, exp) : "R1", "outcome", 64'(outcome), 64'(exp));
    check("R1", "notMine", 64'(notMine), 64'(valid && !match));
    check("R7", "trapClass", 64'(trapClass), (exp == 3 || exp == 4) ? 64'h18 : 64'h0);
    check((exp == 2) ? "R3" : "R7", "redirOffset", 64'(redirOffset), (exp == 2) ? 64'h1C8 : 64'h0);
    check("R8", "rdata", rdata, (exp == 1 && !wr) ? modelReg : 64'h0);
    if (exp == 1 && wr) modelReg = wd & MASK;
  endtask

  task automatic acc(bit wr, logic [63:0] wd, int el, bit [6:0] f);
    doOp(1'b1, wr, 2'd3, 3'd4, 4'd1, 4'd1, 3'd6, wd, el, f);
  endtask

  initial begin
    #(8 * 150000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [63:0] wd;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R10: reset value reads back as zero at level 3
    acc(1'b0, '0, 3, 7'd0);
    check("R10", "reset value", modelReg, 64'h0);

    // R1: idle and foreign encodings (one field off at a time)
    doOp(1'b0, 1'b0, 2'd3, 3'd4, 4'd1, 4'd1, 3'd6, '0, 3, 7'd0);
    doOp(1'b1, 1'b0, 2'd2, 3'd4, 4'd1, 4'd1, 3'd6, '0, 3, 7'd0);
    doOp(1'b1, 1'b1, 2'd3, 3'd0, 4'd1, 4'd1, 3'd6, 64'hFF, 3, 7'd0);
    doOp(1'b1, 1'b0, 2'd3, 3'd4, 4'd2, 4'd1, 3'd6, '0, 3, 7'd0);
    doOp(1'b1, 1'b1, 2'd3, 3'd4, 4'd1, 4'd0, 3'd6, 64'hFF, 2, 7'd0);
    doOp(1'b1, 1'b0, 2'd3, 3'd4, 4'd1, 4'd1, 3'd5, '0, 1, 7'd7);

    // R9: direct write with reserved bits set, then readback
    acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 7'd0);
    acc(1'b0, '0, 3, 7'd0);
    check("R9", "masked store", modelReg, MASK);

    // full sweep of levels, flags, read and write
    for (int el = 0; el < 4; el++) begin
      for (int f = 0; f < 128; f++) begin
        wd = {$urandom, $urandom};
        acc(1'b1, wd, el, 7'(f));
        acc(1'b0, '0, el, 7'(f));
        // R9: non-direct writes must leave the stored value as it was
        acc(1'b0, '0, 3, 7'd0);
      end
    end

    // R8/R9: trapped write with new data, then read at level 3
    acc(1'b1, 64'h1234, 1, 7'b0000101);
    acc(1'b0, '0, 3, 7'd0);
    acc(1'b1, 64'h5678, 2, 7'b1101000);
    acc(1'b0, '0, 3, 7'd0);

    @(negedge clk);
    reqValid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule